// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block is the command front end of a byte-wide nonvolatile memory. It watches single-cycle write events, each with an address and a data byte, and recognises the protected multi-write unlock sequences that guard every operation able to alter stored data or change what reads return. When a sequence completes it raises a one-cycle launch pulse for a byte program or for a chip, sector or block erase, or it switches a read-mode selector between array data, identification data and the capability query table.

Every protected sequence opens with two key writes. A third write at the first key address carries the command byte. Programming and the two query modes need only these three writes. An erase needs a second key pair and a sixth write that names the erase type. A write that breaks a sequence drops the decoder back to idle and is then treated as a possible opening write. A lone exit byte written at any address also returns reads to the array. While the status logic reports an operation in progress, every write is discarded.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: After reset every launch pulse is low, the sequence is idle and the read mode is array (read_mode_o = 0).
- R2: A sequence opens with data AAh at command address 5555h and then data 55h at 2AAAh. Only address bits 14..0 are compared, so the bits above them do not matter.
- R3: A third write of A0h at 5555h arms programming. The next accepted write launches prog_go_o for exactly one cycle, starting after that write's clock edge, with prog_addr_o and prog_data_o equal to that write's full address and data. Any data byte, F0h included, is taken as program data.
- R4: A third write of 80h at 5555h, then AAh at 5555h, then 55h at 2AAAh, then 10h at 5555h pulses erase_chip_o for one cycle with erase_addr_o = 0. A 10h sixth write at any other command address is a mismatch.
- R5: The same five writes followed by 30h at any address pulse erase_sector_o, with erase_addr_o equal to that address with bits 11..0 cleared.
- R6: The same five writes followed by 50h at any address pulse erase_block_o, with erase_addr_o equal to that address with bits 15..0 cleared.
- R7: A third write of 90h at 5555h sets read_mode_o to 1 (identification), and 98h sets it to 2 (query table). The mode then holds through any writes that are not an exit.
- R8: read_mode_o returns to 0 either after a third write of F0h at 5555h or after a single F0h write at any address while the decoder is idle.
- R9: A write that does not match the expected step ends the sequence with no launch and no mode change. That same write is then judged as an opening write: AAh at 5555h starts a new sequence, and F0h acts as the single-write exit.
- R10: While busy_i is high, writes cause no launch and no mode change, and the sequence returns to idle.
- R11: At most one launch output is high in any cycle. A launch appears only in the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal operation in progress; discard writes |
| wr_en_i | input | 1 | One-cycle write event |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| prog_go_o | output | 1 | One-cycle program launch |
| prog_addr_o | output | ADDR_W | Target address of the program launch |
| prog_data_o | output | 8 | Data byte of the program launch |
| erase_chip_o | output | 1 | One-cycle whole-array erase launch |
| erase_sector_o | output | 1 | One-cycle sector erase launch |
| erase_block_o | output | 1 | One-cycle block erase launch |
| erase_addr_o | output | ADDR_W | Aligned base address of the erase |
| read_mode_o | output | 2 | Read source: 0 array, 1 identification, 2 query |

## Verification
A wrong sequence step does not show on any port until a later write. If the decoder sits at the wrong step, a completed sequence gives no launch, gives the wrong launch type, or fires a launch one write too early. This shows in the cycle after the sequence's last write. A wrong abort path shows as a lost restart, so the following key writes fail to launch. A stuck query mode shows on read_mode_o in the cycle after the exit write. The bench therefore compares every output after every clock edge against a step model, and it mixes in writes that break sequences at each position.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  localparam int unsigned CMD_AW = 15;

  localparam logic [CMD_AW-1:0] KEY_A_ADDR = 15'h5555;
  localparam logic [CMD_AW-1:0] KEY_B_ADDR = 15'h2AAA;
  localparam logic [7:0] KEY_A_DATA = 8'hAA;
  localparam logic [7:0] KEY_B_DATA = 8'h55;

  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_LEAVE   = 8'hF0;
  localparam logic [7:0] ER_CHIP    = 8'h10;
  localparam logic [7:0] ER_SECTOR  = 8'h30;
  localparam logic [7:0] ER_BLOCK   = 8'h50;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_PGM, ST_E1, ST_E2, ST_E3
  } seq_e;

  typedef enum logic [2:0] {
    ACT_NONE, ACT_PROG, ACT_ER_CHIP, ACT_ER_SECT, ACT_ER_BLK,
    ACT_IDENT, ACT_QUERY, ACT_LEAVE
  } act_e;

  typedef enum logic [1:0] {
    RM_ARRAY = 2'd0, RM_IDENT = 2'd1, RM_QUERY = 2'd2
  } rmode_e;

  // Step taken by a write that opens (or re-opens) a sequence.
  function automatic seq_e open_state(logic at_a, logic [7:0] d);
    return (at_a && d == KEY_A_DATA) ? ST_K1 : ST_IDLE;
  endfunction

  function automatic act_e open_act(logic [7:0] d);
    return (d == OP_LEAVE) ? ACT_LEAVE : ACT_NONE;
  endfunction

  // Clear the low lsb bits of an address.
  function automatic logic [31:0] align_down(logic [31:0] a, int unsigned lsb);
    return a & ~((32'd1 << lsb) - 32'd1);
  endfunction

endpackage

// File: rtl/ucd_addr_match.sv
module ucd_addr_match
  import ucd_pkg::*;
(
  input  logic [CMD_AW-1:0] cmd_addr_i,
  output logic              at_key_a_o,
  output logic              at_key_b_o
);
  assign at_key_a_o = (cmd_addr_i == KEY_A_ADDR);
  assign at_key_b_o = (cmd_addr_i == KEY_B_ADDR);
endmodule

// File: rtl/ucd_seq.sv
module ucd_seq
  import ucd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy_i,
  input  logic       wr_en_i,
  input  logic       at_key_a_i,
  input  logic       at_key_b_i,
  input  logic [7:0] data_i,
  output seq_e       state_o,
  output act_e       act_o
);
  seq_e state_q, nxt;
  act_e act;
  logic restart;

  always_comb begin
    nxt     = state_q;
    act     = ACT_NONE;
    restart = 1'b0;
    if (busy_i) begin
      nxt = ST_IDLE;
    end else if (wr_en_i) begin
      unique case (state_q)
        ST_IDLE: restart = 1'b1;
        ST_K1: begin
          if (at_key_b_i && data_i == KEY_B_DATA) nxt = ST_K2;
          else restart = 1'b1;
        end
        ST_K2: begin
          nxt = ST_IDLE;
          if (!at_key_a_i) restart = 1'b1;
          else begin
            unique case (data_i)
              OP_PROGRAM: nxt = ST_PGM;
              OP_ERASE:   nxt = ST_E1;
              OP_IDENT:   act = ACT_IDENT;
              OP_QUERY:   act = ACT_QUERY;
              OP_LEAVE:   act = ACT_LEAVE;
              default:    restart = 1'b1;
            endcase
          end
        end
        ST_PGM: begin
          act = ACT_PROG;
          nxt = ST_IDLE;
        end
        ST_E1: begin
          if (at_key_a_i && data_i == KEY_A_DATA) nxt = ST_E2;
          else restart = 1'b1;
        end
        ST_E2: begin
          if (at_key_b_i && data_i == KEY_B_DATA) nxt = ST_E3;
          else restart = 1'b1;
        end
        ST_E3: begin
          nxt = ST_IDLE;
          if (at_key_a_i && data_i == ER_CHIP) act = ACT_ER_CHIP;
          else if (data_i == ER_SECTOR)        act = ACT_ER_SECT;
          else if (data_i == ER_BLOCK)         act = ACT_ER_BLK;
          else restart = 1'b1;
        end
        default: nxt = ST_IDLE;
      endcase
      if (restart) begin
        nxt = open_state(at_key_a_i, data_i);
        act = open_act(data_i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= nxt;
  end

  assign state_o = state_q;
  assign act_o   = act;

  // R10: a busy cycle leaves the sequence idle
  assert_busy_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> state_q == ST_IDLE);

  // R3: an armed program consumes exactly the next accepted write
  assert_pgm_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PGM && wr_en_i && !busy_i) |=> state_q == ST_IDLE);

  // R2: the second key step is only reached from the first
  assert_key_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_K2) |-> $past(state_q) == ST_K1);
endmodule

// File: rtl/ucd_mode.sv
module ucd_mode
  import ucd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  act_e   act_i,
  output rmode_e mode_o
);
  rmode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= RM_ARRAY;
    else begin
      unique case (act_i)
        ACT_IDENT: mode_q <= RM_IDENT;
        ACT_QUERY: mode_q <= RM_QUERY;
        ACT_LEAVE: mode_q <= RM_ARRAY;
        default:   mode_q <= mode_q;
      endcase
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 21,
  parameter int unsigned SECTOR_LSB = 12,
  parameter int unsigned BLOCK_LSB  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              prog_go_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [7:0]        prog_data_o,
  output logic              erase_chip_o,
  output logic              erase_sector_o,
  output logic              erase_block_o,
  output logic [ADDR_W-1:0] erase_addr_o,
  output logic [1:0]        read_mode_o
);
  localparam int unsigned PAD_W = 32 - ADDR_W;

  logic   at_key_a, at_key_b;
  seq_e   seq_state;
  act_e   seq_act;
  rmode_e mode;

  ucd_addr_match u_match (
    .cmd_addr_i (wr_addr_i[CMD_AW-1:0]),
    .at_key_a_o (at_key_a),
    .at_key_b_o (at_key_b)
  );

  ucd_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_i     (busy_i),
    .wr_en_i    (wr_en_i),
    .at_key_a_i (at_key_a),
    .at_key_b_i (at_key_b),
    .data_i     (wr_data_i),
    .state_o    (seq_state),
    .act_o      (seq_act)
  );

  ucd_mode u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .act_i  (seq_act),
    .mode_o (mode)
  );

  logic [31:0] addr_wide, sect_base, blk_base;
  assign addr_wide = {{PAD_W{1'b0}}, wr_addr_i};
  assign sect_base = align_down(addr_wide, SECTOR_LSB);
  assign blk_base  = align_down(addr_wide, BLOCK_LSB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_go_o      <= 1'b0;
      erase_chip_o   <= 1'b0;
      erase_sector_o <= 1'b0;
      erase_block_o  <= 1'b0;
      prog_addr_o    <= '0;
      prog_data_o    <= '0;
      erase_addr_o   <= '0;
    end else begin
      prog_go_o      <= (seq_act == ACT_PROG);
      erase_chip_o   <= (seq_act == ACT_ER_CHIP);
      erase_sector_o <= (seq_act == ACT_ER_SECT);
      erase_block_o  <= (seq_act == ACT_ER_BLK);
      if (seq_act == ACT_PROG) begin
        prog_addr_o <= wr_addr_i;
        prog_data_o <= wr_data_i;
      end
      unique case (seq_act)
        ACT_ER_CHIP: erase_addr_o <= '0;
        ACT_ER_SECT: erase_addr_o <= sect_base[ADDR_W-1:0];
        ACT_ER_BLK:  erase_addr_o <= blk_base[ADDR_W-1:0];
        default:     erase_addr_o <= erase_addr_o;
      endcase
    end
  end

  assign read_mode_o = mode;

  // R11: a launch follows an accepted write
  assert_launch_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go_o || erase_chip_o || erase_sector_o || erase_block_o)
      |-> $past(wr_en_i && !busy_i));

  // R11: never two launches together
  assert_one_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_go_o, erase_chip_o, erase_sector_o, erase_block_o}));

  // R4: whole-array erase needs the sixth write at the first key address
  assert_chip_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    erase_chip_o |-> ($past(wr_addr_i[CMD_AW-1:0]) == KEY_A_ADDR
                      && $past(seq_state) == ST_E3));

  // R5: a sector launch comes from the sixth step
  assert_sector_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_sector_o |-> $past(seq_state) == ST_E3);

  // R3: an armed program with an accepted write launches next cycle
  assert_prog_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_PGM && wr_en_i && !busy_i) |=> prog_go_o);

  // R10: the read mode moves only on an accepted write
  assert_mode_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(read_mode_o) |-> $past(wr_en_i && !busy_i));
endmodule

// File: tb/unlock_cmd_decoder_test.sv
module unlock_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          busy = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          prog_go, er_chip, er_sect, er_blk;
  logic [AW-1:0] prog_addr, er_addr;
  logic [7:0]    prog_data;
  logic [1:0]    rmode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side reference state
  int            m_stage = 0;
  logic [1:0]    m_mode = 2'd0;
  logic [3:0]    e_pulse;
  logic [AW-1:0] e_paddr, e_eaddr;
  logic [7:0]    e_pdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  unlock_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .prog_go_o(prog_go), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .erase_chip_o(er_chip), .erase_sector_o(er_sect), .erase_block_o(er_blk),
    .erase_addr_o(er_addr), .read_mode_o(rmode)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [AW-1:0] clear_low(logic [AW-1:0] a, int n);
    logic [AW-1:0] r = a;
    for (int i = 0; i < n; i++) r[i] = 1'b0;
    return r;
  endfunction

  task automatic reopen(input bit ka, input logic [7:0] d);
    if (ka && d == 8'hAA) m_stage = 1;
    else begin
      m_stage = 0;
      if (d == 8'hF0) m_mode = 2'd0;
    end
  endtask

  task automatic model(input bit en, input bit bz,
                       input logic [AW-1:0] a, input logic [7:0] d);
    bit ka, kb;
    ka = (a[14:0] == 15'h5555);
    kb = (a[14:0] == 15'h2AAA);
    e_pulse = 4'b0000;
    if (bz) m_stage = 0;
    else if (en) begin
      case (m_stage)
        1: if (kb && d == 8'h55) m_stage = 2; else reopen(ka, d);
        2: begin
          if (ka && d == 8'hA0) m_stage = 3;
          else if (ka && d == 8'h80) m_stage = 4;
          else if (ka && d == 8'h90) begin m_mode = 2'd1; m_stage = 0; end
          else if (ka && d == 8'h98) begin m_mode = 2'd2; m_stage = 0; end
          else if (ka && d == 8'hF0) begin m_mode = 2'd0; m_stage = 0; end
          else reopen(ka, d);
        end
        3: begin e_pulse = 4'b1000; e_paddr = a; e_pdata = d; m_stage = 0; end
        4: if (ka && d == 8'hAA) m_stage = 5; else reopen(ka, d);
        5: if (kb && d == 8'h55) m_stage = 6; else reopen(ka, d);
        6: begin
          m_stage = 0;
          if (ka && d == 8'h10) begin e_pulse = 4'b0100; e_eaddr = '0; end
          else if (d == 8'h30) begin e_pulse = 4'b0010; e_eaddr = clear_low(a, 12); end
          else if (d == 8'h50) begin e_pulse = 4'b0001; e_eaddr = clear_low(a, 16); end
          else reopen(ka, d);
        end
        default: reopen(ka, d);
      endcase
    end
  endtask

  // one clock: drive at the falling edge, check just after the rising edge
  task automatic cyc(input bit en, input bit bz, input logic [AW-1:0] a,
                     input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = en; busy = bz; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    model(en, bz, a, d);
    chk(req, "launch pulses", {28'd0, prog_go, er_chip, er_sect, er_blk}, {28'd0, e_pulse});
    if (e_pulse[3]) begin
      chk(req, "program address", {11'd0, prog_addr}, {11'd0, e_paddr});
      chk(req, "program data", {24'd0, prog_data}, {24'd0, e_pdata});
    end
    if (e_pulse[2:0] != 3'b000)
      chk(req, "erase address", {11'd0, er_addr}, {11'd0, e_eaddr});
    chk(req, "read mode", {30'd0, rmode}, {30'd0, m_mode});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input string req);
    cyc(1'b1, 1'b0, a, d, req);
  endtask

  task automatic unlock3(input logic [7:0] cmd, input string req);
    wr(21'h0F5555, 8'hAA, req);
    wr(21'h102AAA, 8'h55, req);
    wr(21'h005555, cmd, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1", "launch pulses", {28'd0, prog_go, er_chip, er_sect, er_blk}, 32'd0);
    chk("R1", "read mode", {30'd0, rmode}, 32'd0);

    // R2, R3: upper address bits ignored; F0h is program data, not exit
    unlock3(8'hA0, "R2");
    wr(21'h1ABCDE, 8'hF0, "R3");
    chk("R3", "program address literal", {11'd0, prog_addr}, 32'h1ABCDE);
    cyc(1'b0, 1'b0, '0, '0, "R3");

    // R4 chip, R4 wrong address, R5 sector, R6 block
    unlock3(8'h80, "R4"); wr(21'h035555, 8'hAA, "R4"); wr(21'h002AAA, 8'h55, "R4");
    wr(21'h1F5555, 8'h10, "R4");
    unlock3(8'h80, "R4"); wr(21'h005555, 8'hAA, "R4"); wr(21'h002AAA, 8'h55, "R4");
    wr(21'h002AAA, 8'h10, "R4");
    unlock3(8'h80, "R5"); wr(21'h005555, 8'hAA, "R5"); wr(21'h002AAA, 8'h55, "R5");
    wr(21'h012345, 8'h30, "R5");
    chk("R5", "sector base literal", {11'd0, er_addr}, 32'h012000);
    unlock3(8'h80, "R6"); wr(21'h005555, 8'hAA, "R6"); wr(21'h002AAA, 8'h55, "R6");
    wr(21'h1BCDEF, 8'h50, "R6");
    chk("R6", "block base literal", {11'd0, er_addr}, 32'h1B0000);

    // R7: identification then query; mode holds over other writes
    unlock3(8'h90, "R7");
    wr(21'h000000, 8'h12, "R7");
    unlock3(8'h98, "R7");
    // R8: single exit at arbitrary address, then full exit
    wr(21'h000123, 8'hF0, "R8");
    unlock3(8'h90, "R8");
    unlock3(8'hF0, "R8");

    // R9: repeated opening write restarts; break mid-erase
    wr(21'h005555, 8'hAA, "R9");
    wr(21'h005555, 8'hAA, "R9");
    wr(21'h002AAA, 8'h55, "R9");
    wr(21'h005555, 8'hA0, "R9");
    wr(21'h000777, 8'h3C, "R9");
    unlock3(8'h80, "R9"); wr(21'h005555, 8'hAA, "R9"); wr(21'h002AAA, 8'h77, "R9");
    wr(21'h004000, 8'h30, "R9");
    unlock3(8'h98, "R9"); wr(21'h005555, 8'hAA, "R9"); wr(21'h001234, 8'hF0, "R9");

    // R10: busy discards writes and clears the sequence
    wr(21'h005555, 8'hAA, "R10"); wr(21'h002AAA, 8'h55, "R10");
    cyc(1'b1, 1'b1, 21'h005555, 8'hA0, "R10");
    wr(21'h000010, 8'h99, "R10");
    unlock3(8'h90, "R10");
    cyc(1'b1, 1'b1, 21'h000000, 8'hF0, "R10");

    // R11 and all others: biased random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      int sel;
      a = AW'($urandom);
      sel = $urandom_range(0, 3);
      if (sel == 0) a[14:0] = 15'h5555;
      else if (sel == 1) a[14:0] = 15'h2AAA;
      case ($urandom_range(0, 10))
        0: d = 8'hAA;  1: d = 8'h55;  2: d = 8'hA0;  3: d = 8'h80;
        4: d = 8'h90;  5: d = 8'h98;  6: d = 8'hF0;  7: d = 8'h10;
        8: d = 8'h30;  9: d = 8'h50;  default: d = 8'($urandom);
      endcase
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 15) == 0, a, d, "R11");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule